// File: doc/BRIEF.md
# Flash Status Poll Sequencer

This block sits between a system agent and a parallel NOR-style flash device. It takes one request at a time, writes a single command byte to the device when the request needs one, and then reads the device's status byte until it can classify the outcome. The status byte carries two toggle bits (bit 6 flips on every read while a program or erase runs; bit 2 flips on reads from a sector being erased or suspended), a time-limit bit (bit 5), and an erase-window bit (bit 3, set once the erase itself has begun).

Toggling is found by comparing two back-to-back status reads from the same address. When the time-limit bit shows up alongside a running toggle, the sequencer reads once more. It declares failure only if the toggle is still running, and in that case it writes a reset command to the device. A host-supplied poll budget bounds the wait. Extra sector-erase commands are guarded by reading the erase-window bit both before and after the write. A query mode reports whether a given sector is currently being erased.

Top module: `fpoll_ctrl`

## Requirements
- R1: While reset is high and after it is released, busy, rsp_valid, fl_we and fl_re are all low until a request arrives.
- R2: A request (req_valid high) is taken only when busy is low. Busy is high from the cycle after acceptance until the response cycle, and is low in the cycle where rsp_valid pulses. A request presented while busy is high has no effect on the flash strobes or on the response.
- R3: Op codes are 0 = program and 1 = erase. For these, the first flash access is one write of req_data to req_addr. It is followed by pairs of consecutive reads at req_addr. When bit 6 and bit 2 are equal in both reads of a pair, the response is code 0 (ok).
- R4: After a program or erase, a pair in which bit 6 is equal but bit 2 differs gives code 1 (suspended-read).
- R5: A pair in which bit 6 differs and bit 5 of the second read is 0 starts another pair. When the number of such busy pairs reaches max_polls (a value of 0 counts as 1), the response is code 5 (timeout).
- R6: A pair in which bit 6 differs and bit 5 of the second read is 1 triggers one more read at req_addr. If bit 6 still differs between the second and third reads, the block writes 0xF0 to address 0 and then responds with code 4 (failed). Otherwise it responds with code 0. This check takes precedence over the poll budget.
- R7: Op code 2 (add sector) first reads the status at req_addr. If bit 3 is 1, the response is code 2 (refused) and no write is issued.
- R8: For op code 2 with bit 3 at 0 in the first read, the block writes req_data to req_addr and then reads again. Bit 3 at 1 in that read gives code 3 (unconfirmed); bit 3 at 0 gives code 0.
- R9: Op code 3 (query) issues two reads at req_addr and no write. It responds with code 6 (sector erasing) if bit 2 differs between the reads, and code 7 (quiet) otherwise.
- R10: fl_we and fl_re are never high together. rsp_valid is a one-cycle pulse two cycles after the last read strobe, or one cycle after the reset-command write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | Operation code |
| req_addr | input | ADDR_W | Flash address for command and status reads |
| req_data | input | 8 | Command byte to write |
| max_polls | input | POLL_W | Busy-pair budget, latched at acceptance |
| busy | output | 1 | Request in progress |
| rsp_valid | output | 1 | Result pulse |
| rsp_code | output | 3 | Result code |
| fl_addr | output | ADDR_W | Flash address |
| fl_wdata | output | 8 | Flash write data |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read strobe, data returned next cycle |
| fl_rdata | input | 8 | Flash read data |

## Verification
Two functions can decide on the same pair of reads: the poll budget running out, and the time-limit bit appearing while bit 6 still toggles. The bench provokes this with a budget of two and a second pair that carries bit 5. The response must then come from the confirming third read, which ends in a reset write and code 4, and not from a timeout. A second race, where the time-limit bit appears just as the toggle stops, is judged by expecting code 0 with no reset write.

// File: rtl/fpoll_pkg.sv
package fpoll_pkg;
    localparam int DW          = 8;
    localparam int BIT_RUN_TOG = 6;
    localparam int BIT_LIMIT   = 5;
    localparam int BIT_WINDOW  = 3;
    localparam int BIT_SECT_TOG = 2;

    typedef enum logic [1:0] {
        OP_PROG   = 2'd0,
        OP_ERASE  = 2'd1,
        OP_ADDSEC = 2'd2,
        OP_QUERY  = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        RES_OK      = 3'd0,
        RES_SUSP    = 3'd1,
        RES_REFUSED = 3'd2,
        RES_UNSURE  = 3'd3,
        RES_FAILED  = 3'd4,
        RES_TIMEOUT = 3'd5,
        RES_ERASING = 3'd6,
        RES_QUIET   = 3'd7
    } res_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_CMD, ST_RD1, ST_RD2, ST_JUDGE, ST_RD3, ST_CONFIRM,
        ST_RST, ST_PRE_RD, ST_PRE_CHK, ST_POST_RD, ST_POST_CHK
    } st_e;
endpackage

// File: rtl/fpoll_toggle.sv
module fpoll_toggle
    import fpoll_pkg::*;
(
    input  logic [DW-1:0] prev,
    input  logic [DW-1:0] curr,
    output logic          run_tog,
    output logic          sect_tog
);
    logic [DW-1:0] diff;
    logic          unused_diff;

    assign diff        = prev ^ curr;
    assign run_tog     = diff[BIT_RUN_TOG];
    assign sect_tog    = diff[BIT_SECT_TOG];
    assign unused_diff = ^{diff[7], diff[5:3], diff[1:0]};
endmodule

// File: rtl/fpoll_budget.sv
module fpoll_budget #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic [W-1:0] limit,
    input  logic         step,
    output logic         last
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] lim;
    } bud_t;

    bud_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (clear) begin
            r_d.cnt = '0;
            r_d.lim = (limit == '0) ? W'(1) : limit;
        end else if (step) begin
            r_d.cnt = r_q.cnt + W'(1);
        end
    end

    assign last = ({1'b0, r_q.cnt} + (W+1)'(1)) >= {1'b0, r_q.lim};

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.cnt <= '0;
            r_q.lim <= W'(1);
        end else begin
            r_q <= r_d;
        end
    end

    // R5: the count of busy pairs never reaches the latched budget
    assert_budget_bound_R5: assert property (@(posedge clk) disable iff (rst)
        r_q.cnt < r_q.lim);
endmodule

// File: rtl/fpoll_ctrl.sv
module fpoll_ctrl
    import fpoll_pkg::*;
#(
    parameter int          ADDR_W     = 20,
    parameter int          POLL_W     = 16,
    parameter logic [7:0]  RESET_CMD  = 8'hF0,
    parameter int          RESET_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_data,
    input  logic [POLL_W-1:0] max_polls,
    output logic              busy,
    output logic              rsp_valid,
    output logic [2:0]        rsp_code,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [7:0]        fl_wdata,
    output logic              fl_we,
    output logic              fl_re,
    input  logic [7:0]        fl_rdata
);
    localparam logic [ADDR_W-1:0] RST_ADDR_V = ADDR_W'(RESET_ADDR);

    typedef struct packed {
        st_e               state;
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
        logic [DW-1:0]     snap;
        logic              busy;
        logic              rsp_valid;
        res_e              rsp_code;
    } ctl_t;

    ctl_t r_q, r_d;
    logic bud_clear, bud_step, bud_last;
    logic run_tog, sect_tog;
    logic fin;
    res_e fin_code;

    fpoll_toggle u_tog (
        .prev     (r_q.snap),
        .curr     (fl_rdata),
        .run_tog  (run_tog),
        .sect_tog (sect_tog)
    );

    fpoll_budget #(.W(POLL_W)) u_bud (
        .clk   (clk),
        .rst   (rst),
        .clear (bud_clear),
        .limit (max_polls),
        .step  (bud_step),
        .last  (bud_last)
    );

    always_comb begin
        r_d           = r_q;
        r_d.rsp_valid = 1'b0;
        bud_clear     = 1'b0;
        bud_step      = 1'b0;
        fin           = 1'b0;
        fin_code      = RES_OK;
        case (r_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.op    = op_e'(req_op);
                    r_d.addr  = req_addr;
                    r_d.data  = req_data;
                    r_d.busy  = 1'b1;
                    bud_clear = 1'b1;
                    case (op_e'(req_op))
                        OP_ADDSEC: r_d.state = ST_PRE_RD;
                        OP_QUERY:  r_d.state = ST_RD1;
                        default:   r_d.state = ST_CMD;
                    endcase
                end
            end
            ST_CMD:   r_d.state = (r_q.op == OP_ADDSEC) ? ST_POST_RD : ST_RD1;
            ST_RD1:   r_d.state = ST_RD2;
            ST_RD2: begin
                r_d.snap  = fl_rdata;
                r_d.state = ST_JUDGE;
            end
            ST_JUDGE: begin
                r_d.snap = fl_rdata;
                if (r_q.op == OP_QUERY) begin
                    fin      = 1'b1;
                    fin_code = sect_tog ? RES_ERASING : RES_QUIET;
                end else if (!run_tog) begin
                    fin      = 1'b1;
                    fin_code = sect_tog ? RES_SUSP : RES_OK;
                end else if (fl_rdata[BIT_LIMIT]) begin
                    r_d.state = ST_RD3;
                end else if (bud_last) begin
                    fin      = 1'b1;
                    fin_code = RES_TIMEOUT;
                end else begin
                    bud_step  = 1'b1;
                    r_d.state = ST_RD1;
                end
            end
            ST_RD3:   r_d.state = ST_CONFIRM;
            ST_CONFIRM: begin
                if (run_tog) begin
                    r_d.state = ST_RST;
                end else begin
                    fin      = 1'b1;
                    fin_code = RES_OK;
                end
            end
            ST_RST: begin
                fin      = 1'b1;
                fin_code = RES_FAILED;
            end
            ST_PRE_RD: r_d.state = ST_PRE_CHK;
            ST_PRE_CHK: begin
                if (fl_rdata[BIT_WINDOW]) begin
                    fin      = 1'b1;
                    fin_code = RES_REFUSED;
                end else begin
                    r_d.state = ST_CMD;
                end
            end
            ST_POST_RD: r_d.state = ST_POST_CHK;
            ST_POST_CHK: begin
                fin      = 1'b1;
                fin_code = fl_rdata[BIT_WINDOW] ? RES_UNSURE : RES_OK;
            end
            default: r_d.state = ST_IDLE;
        endcase
        if (fin) begin
            r_d.state     = ST_IDLE;
            r_d.busy      = 1'b0;
            r_d.rsp_valid = 1'b1;
            r_d.rsp_code  = fin_code;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.state     <= ST_IDLE;
            r_q.op        <= OP_PROG;
            r_q.addr      <= '0;
            r_q.data      <= '0;
            r_q.snap      <= '0;
            r_q.busy      <= 1'b0;
            r_q.rsp_valid <= 1'b0;
            r_q.rsp_code  <= RES_OK;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = r_q.busy;
    assign rsp_valid = r_q.rsp_valid;
    assign rsp_code  = r_q.rsp_code;
    assign fl_we     = (r_q.state == ST_CMD) || (r_q.state == ST_RST);
    assign fl_re     = (r_q.state == ST_RD1) || (r_q.state == ST_RD2) ||
                       (r_q.state == ST_RD3) || (r_q.state == ST_PRE_RD) ||
                       (r_q.state == ST_POST_RD);
    assign fl_addr   = (r_q.state == ST_RST) ? RST_ADDR_V : r_q.addr;
    assign fl_wdata  = (r_q.state == ST_RST) ? RESET_CMD : r_q.data;

    assert_no_dual_strobe_R10: assert property (@(posedge clk) disable iff (rst)
        !(fl_we && fl_re));

    assert_rsp_not_busy_R2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !busy);

    assert_fail_after_reset_write_R6: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_code == RES_FAILED) |->
        ($past(fl_we) && $past(fl_wdata) == RESET_CMD && $past(fl_addr) == RST_ADDR_V));

    assert_refused_no_write_R7: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_code == RES_REFUSED) |-> (!$past(fl_we) && $past(fl_re, 2)));

    assert_cmd_write_R3: assert property (@(posedge clk) disable iff (rst)
        (!busy && req_valid && (req_op == OP_PROG || req_op == OP_ERASE)) |=>
        (fl_we && fl_wdata == $past(req_data) && fl_addr == $past(req_addr)));
endmodule

// File: tb/fpoll_ctrl_test.sv
module fpoll_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [19:0] req_addr = '0;
    logic [7:0]  req_data = '0;
    logic [15:0] max_polls = '0;
    logic        busy, rsp_valid;
    logic [2:0]  rsp_code;
    logic [19:0] fl_addr;
    logic [7:0]  fl_wdata;
    logic        fl_we, fl_re;
    logic [7:0]  fl_rdata = '0;

    fpoll_ctrl uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .max_polls(max_polls),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re),
        .fl_rdata(fl_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit started = 0;
    int n = 0;
    int rsp_due = -1;
    bit mb = 0;
    int exp_code = 0;
    string cur_tag = "R3";
    logic [7:0] sq[$];
    int ek[$];
    int ea[$];
    int ed[$];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic er(input int a);
        ek.push_back(0); ea.push_back(a); ed.push_back(0);
    endtask

    task automatic ew(input int a, input int d);
        ek.push_back(1); ea.push_back(a); ed.push_back(d);
    endtask

    // flash status model: each read returns the next scripted byte one cycle later
    always @(posedge clk) begin
        if (fl_re) begin
            if (sq.size() > 0) fl_rdata <= sq.pop_front();
            else fl_rdata <= 8'h00;
        end
    end

    // reference model: request acceptance and busy window
    always @(posedge clk) begin
        if (rst) begin
            n = 0; mb = 0; rsp_due = -1;
        end else begin
            n = n + 1;
            if (!mb && req_valid) mb = 1;
            else if (mb && n == rsp_due) mb = 0;
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!rst && started) begin
            chk(busy === mb, "R2 busy", busy, mb);
            chk(rsp_valid === (n == rsp_due), "R10 rsp timing", rsp_valid, n == rsp_due);
            if (n == rsp_due)
                chk(rsp_code == 3'(exp_code), cur_tag, rsp_code, exp_code);
            if (fl_we && fl_re) begin
                chk(0, "R10 dual strobe", 1, 0);
            end else if (fl_we || fl_re) begin
                if (ek.size() == 0) begin
                    chk(0, "R2 stray strobe", fl_we, 0);
                end else begin
                    int k, a, d;
                    k = ek.pop_front(); a = ea.pop_front(); d = ed.pop_front();
                    chk(int'(fl_we) == k, {cur_tag, " strobe kind"}, fl_we, k);
                    chk(int'(fl_addr) == a, {cur_tag, " address"}, fl_addr, a);
                    if (k == 1) chk(int'(fl_wdata) == d, {cur_tag, " wdata"}, fl_wdata, d);
                    if (ek.size() == 0) rsp_due = n + (fl_we ? 1 : 2);
                end
            end
        end
    end

    task automatic run(input logic [1:0] op, input int a, input int d, input int maxp,
                       input int code, input string tag, input bit poke);
        exp_code = code;
        cur_tag  = tag;
        @(negedge clk);
        req_valid = 1; req_op = op; req_addr = 20'(a); req_data = 8'(d);
        max_polls = 16'(maxp);
        @(negedge clk);
        req_valid = 0;
        if (poke) begin
            @(negedge clk);
            req_valid = 1; req_op = 2'd3; req_addr = 20'(a + 1);
            @(negedge clk);
            req_valid = 0;
        end
        while (mb) @(negedge clk);
        @(negedge clk);
        chk(ek.size() == 0, {tag, " ops left"}, ek.size(), 0);
        chk(sq.size() == 0, {tag, " reads left"}, sq.size(), 0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual %0d expected done", WATCHDOG);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: quiet outputs in reset
        chk(busy == 0, "R1 busy", busy, 0);
        chk(rsp_valid == 0, "R1 rsp_valid", rsp_valid, 0);
        chk(fl_we == 0, "R1 fl_we", fl_we, 0);
        chk(fl_re == 0, "R1 fl_re", fl_re, 0);
        rst = 0;
        @(negedge clk);
        chk(busy == 0 && fl_we == 0 && fl_re == 0, "R1 after release", busy, 0);
        started = 1;

        // R3: program, done on first pair
        ew('h123, 'hA0); er('h123); er('h123); sq = '{8'h00, 8'h00};
        run(2'd0, 'h123, 'hA0, 4, 0, "R3 program ok", 0);

        // R3/R5: one busy pair then done, with a request poked while busy (R2)
        ew('h200, 'h30); er('h200); er('h200); er('h200); er('h200);
        sq = '{8'h40, 8'h00, 8'h40, 8'h40};
        run(2'd1, 'h200, 'h30, 4, 0, "R2 R3 busy then ok", 1);

        // R4: bit 2 toggles, bit 6 steady
        ew('h300, 'h30); er('h300); er('h300); sq = '{8'h04, 8'h00};
        run(2'd1, 'h300, 'h30, 4, 1, "R4 suspended", 0);

        // R6: limit bit with toggle still running -> reset write, failed
        ew('h400, 'hA0); er('h400); er('h400); er('h400); ew(0, 'hF0);
        sq = '{8'h40, 8'h20, 8'h60};
        run(2'd0, 'h400, 'hA0, 10, 4, "R6 failed", 0);

        // R6: limit bit but toggle stops on confirm read -> ok
        ew('h410, 'hA0); er('h410); er('h410); er('h410);
        sq = '{8'h40, 8'h20, 8'h20};
        run(2'd0, 'h410, 'hA0, 10, 0, "R6 race ok", 0);

        // R5: budget of three busy pairs
        ew('h500, 'hA0);
        for (int i = 0; i < 6; i++) er('h500);
        sq = '{8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40};
        run(2'd0, 'h500, 'hA0, 3, 5, "R5 timeout", 0);

        // R5: budget zero acts as one
        ew('h510, 'hA0); er('h510); er('h510); sq = '{8'h00, 8'h40};
        run(2'd0, 'h510, 'hA0, 0, 5, "R5 zero budget", 0);

        // R6 over R5: limit bit on the last permitted pair
        ew('h600, 'h30);
        for (int i = 0; i < 5; i++) er('h600);
        ew(0, 'hF0);
        sq = '{8'h00, 8'h40, 8'h00, 8'h60, 8'h20};
        run(2'd1, 'h600, 'h30, 2, 4, "R6 precedence", 0);

        // R7: erase window already closed
        er('h700); sq = '{8'h08};
        run(2'd2, 'h700, 'h30, 4, 2, "R7 refused", 0);

        // R8: accepted
        er('h710); ew('h710, 'h30); er('h710); sq = '{8'h00, 8'h00};
        run(2'd2, 'h710, 'h30, 4, 0, "R8 accepted", 0);

        // R8: window closed after the write
        er('h720); ew('h720, 'h30); er('h720); sq = '{8'h00, 8'h08};
        run(2'd2, 'h720, 'h30, 4, 3, "R8 unconfirmed", 0);

        // R9: query, sector erasing
        er('h800); er('h800); sq = '{8'h04, 8'h00};
        run(2'd3, 'h800, 0, 4, 6, "R9 erasing", 0);

        // R9: query, quiet even with bit 6 toggling
        er('h810); er('h810); sq = '{8'h44, 8'h04};
        run(2'd3, 'h810, 0, 4, 7, "R9 quiet", 0);

        repeat (3) @(negedge clk);
        chk(busy == 0 && rsp_valid == 0, "R10 idle at end", busy, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule